// File: doc/BRIEF.md
# Window Framebuffer Fetch Address Generator

This block produces the byte addresses from which a display window reads its pixels. The window can be a sub-rectangle of a wider framebuffer. Each visible line is read as a run of word bursts. After the last burst of a line, the block steps over the part of the framebuffer line that lies outside the window, then continues with the next visible line. A frame-start pulse loads a fresh configuration and restarts the walk at the start address. The walk ends for that frame once the address reaches the end address.

Each burst is presented as an address and a word count on a valid/grant handshake. The burst length and a data swap selector depend on the pixel depth, and are passed on to the downstream unpacking logic. All configuration inputs are sampled only on the frame-start pulse, so software may change them for the next frame while the current one is still being fetched.

Top module: `wfa_fetch_agen`

## Requirements
- R1: Out of reset, req_valid and frame_done are 0 and swap_sel is 0.
- R2: In the cycle after frame_start, req_addr equals the start address that was sampled with the pulse, and req_valid is 1 when the frame is non-empty.
- R3: The full burst length in 32-bit words is 4 at 1 bpp, 8 at 2, 4 and 8 bpp, and 16 at 16, 24 and 32 bpp.
- R4: swap_sel encodes the swap kind as 0 = bit, 1 = byte, 2 = halfword, 3 = word. It is 0 at 1, 2 and 4 bpp, 1 at 8 bpp, 2 at 16 bpp and 3 at 24 and 32 bpp.
- R5: Any other bpp value is handled as 24 bpp: 16-word bursts and swap_sel = 3.
- R6: While req_valid is 1 and req_grant is 0, req_valid, req_addr and req_words hold their values.
- R7: Inside a line, a granted burst advances req_addr by 4 × req_words in the next cycle.
- R8: When fewer words remain in a line than the full burst length, the last burst of that line carries only the remaining words.
- R9: After the last burst of a line is granted, the next address also includes the per-line skip byte count.
- R10: When the next address is at or above the end address, req_valid drops and frame_done rises. Both keep these values until the next frame_start.
- R11: A frame_start in the middle of a frame abandons the current frame and restarts from the new start address.
- R12: A frame whose start address is not below the end address, or whose page width is zero, issues no request. Its frame_done is 1 in the cycle after frame_start.
- R13: Changes to the configuration inputs between frame_start pulses have no effect on the requests of the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse that loads the configuration and begins a frame |
| cfg_start_addr | input | AW | Byte address of the first visible pixel |
| cfg_end_addr | input | AW | Byte address at which fetching stops |
| cfg_page_bytes | input | LW | Visible bytes per line, a multiple of 4 |
| cfg_skip_bytes | input | LW | Bytes skipped after each visible line |
| cfg_bpp | input | BPPW | Bits per pixel |
| req_grant | input | 1 | Memory side accepts the current burst |
| req_valid | output | 1 | A burst request is presented |
| req_addr | output | AW | Byte address of the burst |
| req_words | output | 5 | Number of 32-bit words in the burst |
| swap_sel | output | 2 | Swap kind for the data path (0 bit, 1 byte, 2 halfword, 3 word) |
| frame_done | output | 1 | The current frame has been fully requested |

## Verification
The assertions take some properties of the inputs for granted. The page width is a nonzero multiple of 4 bytes, or is zero for an empty frame. The end address lies on the line grid, at the start address plus a whole number of line strides. Address arithmetic never passes the top of the address space. The stimulus builds every frame from a line count, a page width and a skip, and derives the end address from them, so these properties always hold. Grants come from a pseudo-random bit sequence, with stretches where they are withheld. Configuration is scrambled in the middle of a frame only after the pulse has sampled it.

// File: rtl/wfa_pkg.sv
package wfa_pkg;
  localparam int WORD_BYTES = 4;
  localparam int BWW        = 5;

  typedef enum logic [1:0] {
    SWP_BIT  = 2'd0,
    SWP_BYTE = 2'd1,
    SWP_HALF = 2'd2,
    SWP_WORD = 2'd3
  } swap_e;

  typedef struct packed {
    logic [BWW-1:0] burst_words;
    swap_e          swap;
  } pix_mode_t;
endpackage

// File: rtl/wfa_mode_dec.sv
module wfa_mode_dec
  import wfa_pkg::*;
#(
  parameter int BPPW = 6
) (
  input  logic [BPPW-1:0] bpp,
  output pix_mode_t       mode
);
  always_comb begin
    case (bpp)
      BPPW'(1):           mode = '{burst_words: BWW'(4),  swap: SWP_BIT};
      BPPW'(2), BPPW'(4): mode = '{burst_words: BWW'(8),  swap: SWP_BIT};
      BPPW'(8):           mode = '{burst_words: BWW'(8),  swap: SWP_BYTE};
      BPPW'(16):          mode = '{burst_words: BWW'(16), swap: SWP_HALF};
      default:            mode = '{burst_words: BWW'(16), swap: SWP_WORD};
    endcase
  end
endmodule

// File: rtl/wfa_burst_clip.sv
module wfa_burst_clip
  import wfa_pkg::*;
#(
  parameter int LW = 16
) (
  input  logic [LW-1:0]  left_bytes,
  input  logic [BWW-1:0] max_words,
  output logic [BWW-1:0] words
);
  localparam int LWW = LW - 2;
  logic [LWW-1:0] left_words;

  always_comb begin
    left_words = left_bytes[LW-1:2];
    if (left_words < LWW'(max_words)) words = BWW'(left_words);
    else                              words = max_words;
  end
endmodule

// File: rtl/wfa_fetch_agen.sv
module wfa_fetch_agen
  import wfa_pkg::*;
#(
  parameter int AW   = 32,
  parameter int LW   = 16,
  parameter int BPPW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_start,
  input  logic [AW-1:0]   cfg_start_addr,
  input  logic [AW-1:0]   cfg_end_addr,
  input  logic [LW-1:0]   cfg_page_bytes,
  input  logic [LW-1:0]   cfg_skip_bytes,
  input  logic [BPPW-1:0] cfg_bpp,
  input  logic            req_grant,
  output logic            req_valid,
  output logic [AW-1:0]   req_addr,
  output logic [4:0]      req_words,
  output logic [1:0]      swap_sel,
  output logic            frame_done
);
  // latched frame configuration
  logic [AW-1:0]  end_q;
  logic [LW-1:0]  page_q, skip_q;
  logic [BWW-1:0] blen_q;
  swap_e          swap_q;

  // walk state
  logic [AW-1:0]  addr_q;
  logic [LW-1:0]  left_q;
  logic [BWW-1:0] words_q;
  logic           valid_q, done_q;

  pix_mode_t      new_mode;
  logic [BWW-1:0] load_words, next_words;
  logic [LW-1:0]  step_bytes, left_after;
  logic [AW-1:0]  addr_after;
  logic           line_end, reach_end, frame_live;

  wfa_mode_dec #(.BPPW(BPPW)) u_dec (
    .bpp  (cfg_bpp),
    .mode (new_mode)
  );

  wfa_burst_clip #(.LW(LW)) u_clip_load (
    .left_bytes (cfg_page_bytes),
    .max_words  (new_mode.burst_words),
    .words      (load_words)
  );

  wfa_burst_clip #(.LW(LW)) u_clip_step (
    .left_bytes (left_after),
    .max_words  (blen_q),
    .words      (next_words)
  );

  always_comb begin
    step_bytes = LW'({words_q, 2'b00});
    line_end   = (left_q == step_bytes);
    left_after = line_end ? page_q : (left_q - step_bytes);
    addr_after = addr_q + AW'(step_bytes) + (line_end ? AW'(skip_q) : '0);
    reach_end  = (addr_after >= end_q);
    frame_live = (cfg_start_addr < cfg_end_addr) && (cfg_page_bytes != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      end_q   <= '0;
      page_q  <= '0;
      skip_q  <= '0;
      blen_q  <= '0;
      swap_q  <= SWP_BIT;
      addr_q  <= '0;
      left_q  <= '0;
      words_q <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (frame_start) begin
      end_q   <= cfg_end_addr;
      page_q  <= cfg_page_bytes;
      skip_q  <= cfg_skip_bytes;
      blen_q  <= new_mode.burst_words;
      swap_q  <= new_mode.swap;
      addr_q  <= cfg_start_addr;
      left_q  <= cfg_page_bytes;
      words_q <= load_words;
      valid_q <= frame_live;
      done_q  <= !frame_live;
    end else if (valid_q && req_grant) begin
      addr_q  <= addr_after;
      left_q  <= left_after;
      words_q <= next_words;
      if (reach_end) begin
        valid_q <= 1'b0;
        done_q  <= 1'b1;
      end
    end
  end

  assign req_valid  = valid_q;
  assign req_addr   = addr_q;
  assign req_words  = words_q;
  assign swap_sel   = swap_q;
  assign frame_done = done_q;
endmodule

// File: rtl/wfa_fetch_agen_chk.sv
module wfa_fetch_agen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_start,
  input logic [AW-1:0] cfg_start_addr,
  input logic [AW-1:0] cfg_end_addr,
  input logic          req_grant,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic [4:0]    req_words,
  input logic          frame_done,
  input logic [AW-1:0] end_q
);
  AST_LOAD_START: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> req_addr == $past(cfg_start_addr)); // R2

  AST_BURST_RANGE: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_words != 5'd0 && req_words <= 5'd16)); // R3

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_grant && !frame_start) |=>
      (req_valid && $stable(req_addr) && $stable(req_words))); // R6

  AST_ADDR_FORWARD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_grant && !frame_start) |=>
      (!req_valid || req_addr >= $past(req_addr) + AW'({$past(req_words), 2'b00}))); // R7

  AST_BELOW_END: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_addr < end_q); // R10

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !req_valid); // R10

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !frame_start) |=> frame_done); // R10

  AST_EMPTY_FRAME: assert property (@(posedge clk) disable iff (rst)
    (frame_start && cfg_start_addr >= cfg_end_addr) |=> (!req_valid && frame_done)); // R12
endmodule

bind wfa_fetch_agen wfa_fetch_agen_chk #(.AW(AW)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .frame_start    (frame_start),
  .cfg_start_addr (cfg_start_addr),
  .cfg_end_addr   (cfg_end_addr),
  .req_grant      (req_grant),
  .req_valid      (req_valid),
  .req_addr       (req_addr),
  .req_words      (req_words),
  .frame_done     (frame_done),
  .end_q          (end_q)
);

// File: tb/wfa_fetch_agen_tb.sv
module wfa_fetch_agen_tb;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int BPPW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 1'b0;
  logic [AW-1:0] cfg_start_addr = '0, cfg_end_addr = '0;
  logic [LW-1:0] cfg_page_bytes = '0, cfg_skip_bytes = '0;
  logic [BPPW-1:0] cfg_bpp = '0;
  logic req_grant = 1'b0;
  logic req_valid, frame_done;
  logic [AW-1:0] req_addr;
  logic [4:0] req_words;
  logic [1:0] swap_sel;

  always #4 clk = ~clk; // 125 MHz

  wfa_fetch_agen #(.AW(AW), .LW(LW), .BPPW(BPPW)) u_dut (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .cfg_start_addr(cfg_start_addr), .cfg_end_addr(cfg_end_addr),
    .cfg_page_bytes(cfg_page_bytes), .cfg_skip_bytes(cfg_skip_bytes),
    .cfg_bpp(cfg_bpp), .req_grant(req_grant), .req_valid(req_valid),
    .req_addr(req_addr), .req_words(req_words), .swap_sel(swap_sel),
    .frame_done(frame_done)
  );

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  int unsigned lfsr = 32'h1ace_b00c;

  // behavioural reference model
  int unsigned m_addr, m_end;
  int m_left, m_page, m_skip, m_blen, m_words, m_swap;
  bit m_valid, m_done;

  function automatic void mode_of(input int b, output int blen, output int sw);
    case (b)
      1:       begin blen = 4;  sw = 0; end
      2, 4:    begin blen = 8;  sw = 0; end
      8:       begin blen = 8;  sw = 1; end
      16:      begin blen = 16; sw = 2; end
      default: begin blen = 16; sw = 3; end
    endcase
  endfunction

  function automatic int clip(input int left, input int blen);
    return (left / 4 < blen) ? left / 4 : blen;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_valid = 0; m_done = 0; m_swap = 0; m_addr = 0; m_words = 0;
    end else if (frame_start) begin
      mode_of(int'(cfg_bpp), m_blen, m_swap);
      m_addr = cfg_start_addr; m_end = cfg_end_addr;
      m_page = int'(cfg_page_bytes); m_skip = int'(cfg_skip_bytes);
      m_left = m_page;
      m_words = clip(m_left, m_blen);
      m_valid = (cfg_start_addr < cfg_end_addr) && (m_page != 0);
      m_done = !m_valid;
    end else if (m_valid && req_grant) begin
      m_addr = m_addr + 4 * m_words;
      m_left = m_left - 4 * m_words;
      if (m_left == 0) begin
        m_addr = m_addr + m_skip;
        m_left = m_page;
      end
      m_words = clip(m_left, m_blen);
      if (m_addr >= m_end) begin
        m_valid = 0; m_done = 1;
      end
    end
  end

  task automatic cmp(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      cmp("req_valid", req_valid, m_valid);
      cmp("frame_done", frame_done, m_done);
      cmp("swap_sel", swap_sel, m_swap);
      if (m_valid) begin
        cmp("req_addr", req_addr, m_addr);
        cmp("req_words", req_words, m_words);
      end
    end
  end

  task automatic start_frame(input int bpp, input int unsigned st,
                             input int page, input int skip, input int lines);
    @(negedge clk);
    cfg_bpp = BPPW'(bpp);
    cfg_start_addr = st;
    cfg_page_bytes = LW'(page);
    cfg_skip_bytes = LW'(skip);
    cfg_end_addr = st + lines * (page + skip);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // gmode 0: random grants, 1: always grant
  task automatic run_to_done(input int gmode, input int max_cycles);
    for (int i = 0; i < max_cycles; i++) begin
      if (frame_done) break;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      req_grant = (gmode == 1) ? 1'b1 : lfsr[0];
      @(negedge clk);
    end
    req_grant = 1'b0;
    cmp("frame_done at end of run", frame_done, 1);
  endtask

  task automatic scramble_cfg();
    cfg_bpp = 6'd1;
    cfg_start_addr = 32'h0;
    cfg_end_addr = 32'hffff_0000;
    cfg_page_bytes = 16'd4;
    cfg_skip_bytes = 16'd1000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    cmp("req_valid in reset", req_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    cmp("idle valid after reset", req_valid, 0);
    cmp("idle done after reset", frame_done, 0);
    cmp("idle swap after reset", swap_sel, 0);

    cur_req = "R2/R3/R4/R8/R9/R10";
    start_frame(32, 32'h1000, 80, 48, 3);
    cmp("first req_addr", req_addr, 32'h1000);
    cmp("first req_words 32bpp", req_words, 16);
    cmp("swap 32bpp", swap_sel, 3);
    run_to_done(0, 2000);

    cur_req = "R3/R4/R8";
    start_frame(1, 32'h2000, 24, 8, 2);
    cmp("first words 1bpp", req_words, 4);
    cmp("swap 1bpp", swap_sel, 0);
    run_to_done(1, 2000);

    cur_req = "R3/R4";
    start_frame(2, 32'h3000, 64, 0, 2);
    cmp("swap 2bpp", swap_sel, 0);
    run_to_done(0, 2000);
    start_frame(4, 32'h3400, 40, 24, 3);
    cmp("words 4bpp", req_words, 8);
    run_to_done(0, 2000);
    start_frame(8, 32'h3800, 36, 12, 2);
    cmp("swap 8bpp", swap_sel, 1);
    run_to_done(1, 2000);
    start_frame(16, 32'h4000, 100, 28, 2);
    cmp("swap 16bpp", swap_sel, 2);
    run_to_done(0, 2000);
    start_frame(24, 32'h4800, 72, 0, 2);
    cmp("swap 24bpp", swap_sel, 3);
    run_to_done(0, 2000);

    cur_req = "R5";
    start_frame(7, 32'h5000, 96, 32, 2);
    cmp("words unsupported bpp", req_words, 16);
    cmp("swap unsupported bpp", swap_sel, 3);
    run_to_done(0, 2000);

    cur_req = "R6";
    start_frame(16, 32'h6000, 128, 0, 2);
    req_grant = 1'b0;
    repeat (6) @(negedge clk);
    cmp("held addr without grant", req_addr, 32'h6000);
    cmp("held valid without grant", req_valid, 1);
    run_to_done(0, 2000);

    cur_req = "R7";
    start_frame(32, 32'h6800, 256, 0, 1);
    req_grant = 1'b1;
    @(negedge clk);
    req_grant = 1'b0;
    cmp("addr after one grant", req_addr, 32'h6840);
    run_to_done(1, 2000);

    cur_req = "R11";
    start_frame(8, 32'h7000, 64, 64, 4);
    req_grant = 1'b1;
    repeat (3) @(negedge clk);
    req_grant = 1'b0;
    start_frame(16, 32'h8000, 48, 16, 2);
    cmp("restart addr", req_addr, 32'h8000);
    run_to_done(0, 2000);

    cur_req = "R12";
    @(negedge clk);
    cfg_start_addr = 32'h9000; cfg_end_addr = 32'h9000;
    cfg_page_bytes = 16'd32; cfg_bpp = 6'd32;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    cmp("empty frame valid", req_valid, 0);
    cmp("empty frame done", frame_done, 1);
    start_frame(16, 32'h9100, 0, 16, 2);
    cmp("zero page done", frame_done, 1);

    cur_req = "R13";
    start_frame(16, 32'ha000, 88, 40, 3);
    scramble_cfg();
    run_to_done(0, 2000);
    cmp("swap kept after cfg change", swap_sel, 2);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: frame_done=%0d expected 1", frame_done);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule